// File: doc/BRIEF.md
# Transmit Start and Collision Retry Controller

This block sequences the sending of one Ethernet frame held in a paged packet buffer. Software places the frame in buffer memory, presents a start page and a 16-bit byte count, and pulses a transmit command. The controller then clears its status and its collision count. It fetches frame bytes from the buffer into an external FIFO and raises a one-cycle transmit-start to the MAC. That pulse comes only when three gates hold together: the interframe gap has elapsed, the FIFO is not empty, and any post-collision backoff has run out.

During the frame the controller watches the MAC's collision input. On a collision it flushes the FIFO, rewinds the fetch pointer and remaining count to the start of the frame, restarts the gap timer and draws a random backoff from an LFSR. It then tries again. When the sixteenth attempt also collides (the first send plus fifteen retransmissions), it gives up and flags an abort. A clean end of frame reported by the MAC sets the transmitted flag. The command bit clears itself at the end of a frame and on an abort.

Top module: `txseq_ctrl`

## Requirements
- R1: A `tx_go` pulse while `tx_cmd` is 0 sets `tx_cmd` and clears `stat_ptx`, `stat_col`, `stat_abt` and `col_count` on the next cycle. A `tx_go` pulse while `tx_cmd` is 1 has no effect on the frame in progress, its addresses or its counters.
- R2: After a command the block requests bytes at address `{cfg_page, 8'h00}`, then at successive addresses, one per cycle where `fetch_req` and `fetch_ack` are both high. It requests no more than `cfg_len` bytes. `fetch_last` is high together with the request for the final byte.
- R3: `mac_tx_start` is a one-cycle pulse. It is raised only when the gap timer has expired, `fifo_empty` was low and the backoff timer has expired, all in the cycle before. It never occurs while no command is active.
- R4: The gap timer reloads IFG_CYCLES (default 24) on every frame end, collision and abort. The next `mac_tx_start` is registered no earlier than IFG_CYCLES+1 clock edges after the edge that saw the event.
- R5: A collision during a frame drives `fifo_flush` high in that same cycle. On the next cycle the fetch address is back at the frame start with the full byte count remaining.
- R6: Each collision sets `stat_col` and raises `col_count` by one. `col_count` saturates at 15 and only a new accepted command clears it.
- R7: After the n-th collision, the wait before the retry start is a whole number of slots, between 0 and 2^min(n,10)-1 slots of SLOT_CYCLES clocks, and never shorter than the gap.
- R8: A collision on the sixteenth attempt sets `stat_abt`, clears `tx_cmd`, stops fetching, and no further `mac_tx_start` follows.
- R9: `mac_tx_done` during a frame with no collision in the same cycle sets `stat_ptx` and clears `tx_cmd`. `stat_abt` stays 0.
- R10: After reset `tx_cmd`, `fetch_req`, `fifo_flush`, `mac_tx_start`, all status flags and `col_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one nibble time per cycle) |
| rst_n | input | 1 | Active-low reset |
| tx_go | input | 1 | Transmit command pulse |
| cfg_page | input | PAGE_W | Buffer page holding the frame start |
| cfg_len | input | LEN_W | Frame length in bytes |
| fifo_empty | input | 1 | FIFO holds no bytes |
| fetch_ack | input | 1 | Requested byte written into the FIFO this cycle |
| mac_collision | input | 1 | Collision seen during the current frame |
| mac_tx_done | input | 1 | Frame finished on the wire |
| tx_cmd | output | 1 | Command bit, clears itself at frame end or abort |
| fetch_req | output | 1 | Byte fetch request |
| fetch_addr | output | PAGE_W+8 | Buffer address of the requested byte |
| fetch_last | output | 1 | Request is for the final frame byte |
| fifo_flush | output | 1 | Discard FIFO contents |
| mac_tx_start | output | 1 | Start-of-transmission pulse to the MAC |
| stat_ptx | output | 1 | Frame sent without a final collision |
| stat_col | output | 1 | At least one collision occurred |
| stat_abt | output | 1 | Frame abandoned after too many collisions |
| col_count | output | clog2(MAX_RETRY+1) | Saturating collision count |

## Verification
The bound checker watches several rules on every cycle. A start pulse must follow all three gate signals and an active command. The command must clear the status registers. Each flush must leave the fetch pointer on a page boundary, and the collision count may step by at most one. A raised abort or transmitted flag must coincide with an idle command bit. Things that need the whole frame sequence are shown only by the bench's scenarios: the exact fetch address stream across rewinds, the gap and backoff windows measured against the collision index, abort on the sixteenth collision with no later start, and a command ignored while busy.

// File: rtl/txseq_pkg.sv
`timescale 1ns/1ps
package txseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_SEND = 2'd2
  } tx_state_e;

  // Next state of a 16-bit maximal-length Fibonacci LFSR (taps 16,14,13,11).
  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[14:0], fb};
  endfunction

  // Slot mask for the n-th collision: 2^min(n,lim) - 1.
  function automatic logic [15:0] backoff_mask(input int unsigned n, input int unsigned lim);
    int unsigned e;
    e = (n < lim) ? n : lim;
    return 16'((32'd1 << e) - 32'd1);
  endfunction

endpackage

// File: rtl/txseq_ifg_timer.sv
`timescale 1ns/1ps
module txseq_ifg_timer #(
  parameter int IFG_CYCLES = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic done
);
  localparam int W = $clog2(IFG_CYCLES + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (restart)
      cnt <= W'(IFG_CYCLES);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/txseq_backoff.sv
`timescale 1ns/1ps
module txseq_backoff
  import txseq_pkg::*;
#(
  parameter int SLOT_CYCLES = 128,
  parameter int LIMIT       = 10,
  parameter int ATT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ATT_W-1:0] attempt,
  output logic             done
);
  localparam int SUB_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;

  logic [15:0]      lfsr;
  logic [LIMIT-1:0] slots;
  logic [SUB_W-1:0] sub;
  logic [LIMIT-1:0] draw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= lfsr_next(lfsr);
  end

  assign draw = lfsr[LIMIT-1:0] & LIMIT'(backoff_mask(32'(attempt), LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots <= '0;
      sub   <= '0;
    end else if (load) begin
      slots <= draw;
      sub   <= SUB_W'(SLOT_CYCLES - 1);
    end else if (slots != '0) begin
      if (sub == '0) begin
        sub   <= SUB_W'(SLOT_CYCLES - 1);
        slots <= slots - 1'b1;
      end else begin
        sub <= sub - 1'b1;
      end
    end
  end

  assign done = (slots == '0);
endmodule

// File: rtl/txseq_dma.sv
`timescale 1ns/1ps
module txseq_dma #(
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              restore,
  input  logic              active,
  input  logic              ack,
  input  logic [PAGE_W-1:0] page,
  input  logic [LEN_W-1:0]  len,
  output logic              req,
  output logic [PAGE_W+7:0] addr,
  output logic              last
);
  localparam int ADDR_W = PAGE_W + 8;

  logic [ADDR_W-1:0] ptr, base_ptr;
  logic [LEN_W-1:0]  rem, base_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      base_ptr <= '0;
      rem      <= '0;
      base_len <= '0;
    end else if (load) begin
      ptr      <= {page, 8'h00};
      base_ptr <= {page, 8'h00};
      rem      <= len;
      base_len <= len;
    end else if (restore) begin
      ptr <= base_ptr;
      rem <= base_len;
    end else if (req && ack) begin
      ptr <= ptr + 1'b1;
      rem <= rem - 1'b1;
    end
  end

  assign req  = active && (rem != '0);
  assign last = req && (rem == LEN_W'(1));
  assign addr = ptr;
endmodule

// File: rtl/txseq_ctrl.sv
`timescale 1ns/1ps
module txseq_ctrl
  import txseq_pkg::*;
#(
  parameter int PAGE_W        = 8,
  parameter int LEN_W         = 16,
  parameter int IFG_CYCLES    = 24,
  parameter int SLOT_CYCLES   = 128,
  parameter int BACKOFF_LIMIT = 10,
  parameter int MAX_RETRY     = 15
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tx_go,
  input  logic [PAGE_W-1:0]                cfg_page,
  input  logic [LEN_W-1:0]                 cfg_len,
  input  logic                             fifo_empty,
  input  logic                             fetch_ack,
  input  logic                             mac_collision,
  input  logic                             mac_tx_done,
  output logic                             tx_cmd,
  output logic                             fetch_req,
  output logic [PAGE_W+7:0]                fetch_addr,
  output logic                             fetch_last,
  output logic                             fifo_flush,
  output logic                             mac_tx_start,
  output logic                             stat_ptx,
  output logic                             stat_col,
  output logic                             stat_abt,
  output logic [$clog2(MAX_RETRY+1)-1:0]   col_count
);
  localparam int CC_W  = $clog2(MAX_RETRY + 1);
  localparam int ATT_W = $clog2(MAX_RETRY + 2);

  tx_state_e        state, state_n;
  logic [ATT_W-1:0] attempts;

  // Named internal events, visible to the bound checker.
  logic ifg_done, bo_done;
  logic cmd_accept, start_ok, col_event, good_done, give_up, ifg_restart, bo_load;

  always_comb begin
    cmd_accept  = tx_go && (state == ST_IDLE);
    start_ok    = (state == ST_ARM) && ifg_done && bo_done && !fifo_empty;
    col_event   = (state == ST_SEND) && mac_collision;
    good_done   = (state == ST_SEND) && mac_tx_done && !mac_collision;
    give_up     = col_event && (attempts == ATT_W'(MAX_RETRY));
    ifg_restart = col_event || good_done;
    bo_load     = col_event && !give_up;
  end

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: if (cmd_accept) state_n = ST_ARM;
      ST_ARM:  if (start_ok)   state_n = ST_SEND;
      ST_SEND: begin
        if (give_up)        state_n = ST_IDLE;
        else if (col_event) state_n = ST_ARM;
        else if (good_done) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      attempts     <= '0;
      mac_tx_start <= 1'b0;
      stat_ptx     <= 1'b0;
      stat_col     <= 1'b0;
      stat_abt     <= 1'b0;
      col_count    <= '0;
    end else begin
      state        <= state_n;
      mac_tx_start <= start_ok;
      if (cmd_accept) begin
        attempts  <= '0;
        stat_ptx  <= 1'b0;
        stat_col  <= 1'b0;
        stat_abt  <= 1'b0;
        col_count <= '0;
      end else begin
        if (col_event) begin
          attempts <= attempts + 1'b1;
          stat_col <= 1'b1;
          if (col_count != CC_W'(MAX_RETRY))
            col_count <= col_count + 1'b1;
        end
        if (give_up)   stat_abt <= 1'b1;
        if (good_done) stat_ptx <= 1'b1;
      end
    end
  end

  assign tx_cmd     = (state != ST_IDLE);
  assign fifo_flush = col_event;

  txseq_ifg_timer #(
    .IFG_CYCLES(IFG_CYCLES)
  ) u_ifg (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(ifg_restart),
    .done   (ifg_done)
  );

  txseq_backoff #(
    .SLOT_CYCLES(SLOT_CYCLES),
    .LIMIT      (BACKOFF_LIMIT),
    .ATT_W      (ATT_W)
  ) u_backoff (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (bo_load),
    .attempt(attempts + 1'b1),
    .done   (bo_done)
  );

  txseq_dma #(
    .PAGE_W(PAGE_W),
    .LEN_W (LEN_W)
  ) u_dma (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cmd_accept),
    .restore(col_event),
    .active (state != ST_IDLE),
    .ack    (fetch_ack),
    .page   (cfg_page),
    .len    (cfg_len),
    .req    (fetch_req),
    .addr   (fetch_addr),
    .last   (fetch_last)
  );
endmodule

// File: rtl/txseq_ctrl_sva.sv
`timescale 1ns/1ps
module txseq_ctrl_sva #(
  parameter int CC_W   = 4,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_accept,
  input logic              ifg_done,
  input logic              bo_done,
  input logic              fifo_empty,
  input logic              mac_tx_start,
  input logic              tx_cmd,
  input logic              stat_ptx,
  input logic              stat_col,
  input logic              stat_abt,
  input logic [CC_W-1:0]   col_count,
  input logic              fifo_flush,
  input logic [ADDR_W-1:0] fetch_addr
);
  a_r1_clear_on_go: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> (tx_cmd && !stat_ptx && !stat_col && !stat_abt && col_count == '0));

  a_r3_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    mac_tx_start |-> $past(ifg_done && bo_done && !fifo_empty));

  a_r3_start_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    mac_tx_start |-> tx_cmd);

  a_r5_flush_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> (fetch_addr[7:0] == 8'h00));

  a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_accept |=> (({1'b0, col_count} == {1'b0, $past(col_count)}) ||
                     ({1'b0, col_count} == {1'b0, $past(col_count)} + 1'b1)));

  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_abt) |-> !tx_cmd);

  a_r9_ptx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_ptx) |-> (!tx_cmd && !stat_abt));
endmodule

bind txseq_ctrl txseq_ctrl_sva #(
  .CC_W  ($clog2(MAX_RETRY + 1)),
  .ADDR_W(PAGE_W + 8)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_accept  (cmd_accept),
  .ifg_done    (ifg_done),
  .bo_done     (bo_done),
  .fifo_empty  (fifo_empty),
  .mac_tx_start(mac_tx_start),
  .tx_cmd      (tx_cmd),
  .stat_ptx    (stat_ptx),
  .stat_col    (stat_col),
  .stat_abt    (stat_abt),
  .col_count   (col_count),
  .fifo_flush  (fifo_flush),
  .fetch_addr  (fetch_addr)
);

// File: tb/txseq_ctrl_test.sv
`timescale 1ns/1ps
module txseq_ctrl_test;
  localparam int IFG  = 24;
  localparam int SLOT = 4;
  localparam int LIM  = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_go = 1'b0;
  logic [7:0]  cfg_page = '0;
  logic [15:0] cfg_len = '0;
  logic        fifo_empty, fetch_ack;
  logic        mac_collision = 1'b0, mac_tx_done = 1'b0;
  logic        tx_cmd, fetch_req, fetch_last, fifo_flush, mac_tx_start;
  logic [15:0] fetch_addr;
  logic        stat_ptx, stat_col, stat_abt;
  logic [3:0]  col_count;

  always #10 clk = ~clk;

  txseq_ctrl #(.SLOT_CYCLES(SLOT)) uut (
    .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .cfg_page(cfg_page), .cfg_len(cfg_len),
    .fifo_empty(fifo_empty), .fetch_ack(fetch_ack), .mac_collision(mac_collision),
    .mac_tx_done(mac_tx_done), .tx_cmd(tx_cmd), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_last(fetch_last), .fifo_flush(fifo_flush),
    .mac_tx_start(mac_tx_start), .stat_ptx(stat_ptx), .stat_col(stat_col),
    .stat_abt(stat_abt), .col_count(col_count)
  );

  int checks = 0, errors = 0, cyc = 0, starts = 0, fifo_cnt = 0;
  int last_ev = -100000;
  logic ack_en = 1'b0;
  logic [15:0] frm_base = '0;
  int frm_len = 0;
  logic [15:0] exp_ptr = '0;
  int exp_rem = 0;

  assign fetch_ack  = fetch_req & ack_en;
  assign fifo_empty = (fifo_cnt == 0);

  // Simple FIFO occupancy model fed by acknowledged fetches.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fifo_flush) fifo_cnt <= 0;
    else if (fetch_req && fetch_ack) fifo_cnt <= fifo_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bmask(input int n);
    int e;
    e = (n < LIM) ? n : LIM;
    return (1 << e) - 1;
  endfunction

  // Fetch-stream monitor, sampling 5 ns before each rising edge.
  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      if (mac_tx_start) starts++;
      if (tx_go && !tx_cmd) begin
        exp_ptr = {cfg_page, 8'h00};
        exp_rem = cfg_len;
      end else if (mac_collision && tx_cmd) begin
        exp_ptr = frm_base;          // R5 rewind expected
        exp_rem = frm_len;
      end else if (fetch_req) begin
        if (exp_rem == 0)
          check(1'b0, "R2 request beyond length", 1, 0);
        else if (fetch_ack) begin
          check(fetch_addr == exp_ptr, "R2 fetch address", fetch_addr, exp_ptr);
          check(fetch_last == (exp_rem == 1), "R2 last flag", fetch_last, exp_rem == 1);
          exp_ptr = exp_ptr + 1'b1;
          exp_rem = exp_rem - 1;
        end
      end
    end
  end

  task automatic go_cmd(input logic [7:0] page, input logic [15:0] len);
    @(negedge clk);
    cfg_page = page; cfg_len = len; tx_go = 1'b1;
    frm_base = {page, 8'h00}; frm_len = len;
    @(negedge clk);
    tx_go = 1'b0;
    check(tx_cmd == 1'b1, "R1 command set", tx_cmd, 1);
    check({stat_ptx, stat_col, stat_abt} == 3'b000, "R1 status cleared",
          {stat_ptx, stat_col, stat_abt}, 0);
    check(col_count == 4'd0, "R1 count cleared", col_count, 0);
  endtask

  task automatic wait_start(input int ncol);
    int d;
    ack_en = 1'b1;
    for (int i = 0; i < 6000 && !mac_tx_start; i++) @(negedge clk);
    check(mac_tx_start == 1'b1, "R3 start seen", mac_tx_start, 1);
    d = cyc - last_ev;
    check(d >= IFG + 2, "R4 gap respected", d, IFG + 2);
    if (ncol > 0) begin
      d = (bmask(ncol) * SLOT > IFG) ? bmask(ncol) * SLOT : IFG;
      check(cyc - last_ev <= d + 2, "R7 backoff window", cyc - last_ev, d + 2);
    end
  endtask

  task automatic send_frame(input logic [7:0] page, input logic [15:0] len, input int ncol);
    go_cmd(page, len);
    for (int n = 0; n <= ncol; n++) begin
      wait_start(n);
      repeat ($urandom_range(2, int'(len) + 3)) begin
        ack_en = ($urandom % 4) != 0;
        @(negedge clk);
      end
      if (n < ncol) begin
        mac_collision = 1'b1;
        last_ev = cyc;
        #1;
        check(fifo_flush == 1'b1, "R5 flush on collision", fifo_flush, 1);
        @(negedge clk);
        mac_collision = 1'b0;
        check(stat_col == 1'b1, "R6 collision flag", stat_col, 1);
        check(col_count == ((n + 1 > 15) ? 15 : n + 1), "R6 collision count",
              col_count, (n + 1 > 15) ? 15 : n + 1);
        if (n == 15) begin
          check(stat_abt == 1'b1, "R8 abort flag", stat_abt, 1);
          check(tx_cmd == 1'b0, "R8 command cleared", tx_cmd, 0);
          return;
        end
      end else begin
        mac_tx_done = 1'b1;
        last_ev = cyc;
        @(negedge clk);
        mac_tx_done = 1'b0;
        check(stat_ptx == 1'b1, "R9 transmitted flag", stat_ptx, 1);
        check(tx_cmd == 1'b0, "R9 command cleared", tx_cmd, 0);
        check(stat_abt == 1'b0, "R9 no abort", stat_abt, 0);
        check(stat_col == (ncol > 0), "R6 flag matches history", stat_col, ncol > 0);
      end
    end
  endtask

  initial begin
    int s0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check({tx_cmd, fetch_req, fifo_flush, mac_tx_start} == 4'b0, "R10 control outputs",
          {tx_cmd, fetch_req, fifo_flush, mac_tx_start}, 0);
    check({stat_ptx, stat_col, stat_abt} == 3'b0 && col_count == 0, "R10 status",
          {stat_ptx, stat_col, stat_abt, col_count}, 0);

    // R3: no start while the FIFO stays empty
    go_cmd(8'h12, 16'd5);
    ack_en = 1'b0;
    s0 = starts;
    repeat (40) @(negedge clk);
    check(starts == s0, "R3 held while FIFO empty", starts - s0, 0);
    wait_start(0);
    // R1: command while busy is ignored
    @(negedge clk);
    cfg_page = 8'h55; cfg_len = 16'd9; tx_go = 1'b1;
    @(negedge clk);
    tx_go = 1'b0;
    check(tx_cmd == 1'b1, "R1 busy command ignored", tx_cmd, 1);
    check(col_count == 0, "R1 busy count kept", col_count, 0);
    repeat (8) @(negedge clk);
    mac_tx_done = 1'b1; last_ev = cyc;
    @(negedge clk);
    mac_tx_done = 1'b0;
    check(stat_ptx == 1'b1, "R9 directed frame done", stat_ptx, 1);

    // Back-to-back frame right after completion: R4 gap
    send_frame(8'h03, 16'd1, 1);
    // Constrained random frames
    for (int k = 0; k < 10; k++)
      send_frame(8'($urandom), 16'($urandom_range(1, 40)), $urandom_range(0, 4));
    // Page-crossing length with retries
    send_frame(8'h7F, 16'd300, 2);

    // R8: sixteen collisions abort the frame
    send_frame(8'h30, 16'd3, 16);
    s0 = starts;
    repeat (100) @(negedge clk);
    check(starts == s0, "R8 no start after abort", starts - s0, 0);
    check(fetch_req == 1'b0, "R8 fetching stopped", fetch_req, 0);
    check(col_count == 4'd15, "R6 count saturated", col_count, 15);

    // New command clears the saturated count (R1)
    send_frame(8'h21, 16'd4, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule